// File: doc/BRIEF.md
# Storage Controller Status and Interrupt Register File

This block is the byte-wide register file that sits between software and the command engine of a bus-attached storage-interface controller. It keeps the readable status, interrupt-reason, sequence-step, flag, command and configuration copies, the write-side transfer-count bytes and the state that drives one active-high interrupt line. Software reaches it through a single address, a write strobe, a read strobe and byte-wide data. Read data is registered and appears in the cycle after the read strobe.

A command decoder elsewhere in the controller reports events through pulses. A reason pulse ORs its bits into the interrupt-reason register and raises the interrupt. A count-done pulse sets the count-done status bit. The block executes only the two commands that belong to its own state: chip reset and bus reset. Every other opcode written to the command register is only stored, apart from the DMA flag, which loads the written count bytes into their readable copies.

Top module: `ctl_status_regs`

## Requirements
- R1: After reset, every readable register reads 0x00 except configuration 1 (address 8), which reads 0x07. The interrupt output is low, and the high count byte (address 2) reads the chip identity 0xA2.
- R2: A reason pulse ORs its byte into the interrupt-reason register (address 5). In the following cycle the interrupt output and status bit 7 (address 4) are high.
- R3: A read of address 5 returns the value that address held before the read. The same access clears that register and status bit 4 (count done), writes 0x04 into the sequence-step register (address 6) and drops the interrupt output.
- R4: Address 2 reads the chip identity until the first write to it after reset. From then on it returns the readable high count byte.
- R5: A write to any count byte (addresses 0, 1, 2) clears status bit 4, which a count-done pulse sets.
- R6: A command write (address 3) with bit 7 set copies the three written count bytes into their readable copies. With bit 7 clear it leaves the readable counts unchanged. The readable command register returns the last command byte.
- R7: Command opcode 0x03 (bits 6:0) sets the interrupt-reason register to 0x80. It raises the interrupt only while configuration 1 bit 6 is clear.
- R8: Command opcode 0x02 restores every R1 default, including the identity readback, and drops the interrupt output.
- R9: Writes to addresses 8 to 12 read back unchanged. Writes to addresses 4 to 7 and 13 to 15 leave every readable value unchanged.
- R10: When a read and a write arrive in the same cycle, only the write takes effect. The read has no side effect and the read data keeps its previous value.
- R11: A reason pulse in the same cycle as a read of address 5 survives the clear. Its bits remain in the register and the interrupt stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data, valid the cycle after rd_en |
| ev_valid | input | 1 | Interrupt-reason event pulse from the command decoder |
| ev_reason | input | 8 | Reason bits ORed in on ev_valid |
| ev_count_done | input | 1 | Sets the count-done status bit |
| irq | output | 1 | Registered active-high interrupt |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions. One is a reason pulse that lands on the very edge where a destructive read clears the register. The other is a read strobe that shares its cycle with a write. The stimulus first raises an interrupt with a known reason. It then drives both strobes, or the strobe and the pulse, on one falling edge. Afterwards it reads back the surviving reason byte and the interrupt level. The identity readback is set up with a write to the high count byte that carries no DMA load, so the stored copy (zero) can be told apart from the identity constant.

// File: rtl/csr_pkg.sv
package csr_pkg;
    localparam int DW   = 8;
    localparam int AW   = 4;
    localparam int NREG = 1 << AW;

    typedef logic [DW-1:0] regbyte_t;
    typedef logic [NREG-1:0][DW-1:0] regfile_t;

    // register addresses
    localparam int A_CNT_LO  = 0;
    localparam int A_CNT_MID = 1;
    localparam int A_CNT_HI  = 2;
    localparam int A_CMD     = 3;
    localparam int A_STAT    = 4;
    localparam int A_INTR    = 5;
    localparam int A_SEQ     = 6;
    localparam int A_FLAGS   = 7;
    localparam int A_CFG1    = 8;
    localparam int A_CFG2    = 9;
    localparam int A_CFG3    = 10;
    localparam int A_SPARE0  = 11;
    localparam int A_SPARE1  = 12;

    // bit positions
    localparam int ST_INT       = 7;
    localparam int ST_DONE      = 4;
    localparam int CMD_DMA      = 7;
    localparam int CFG1_NOREPORT = 6;

    localparam regbyte_t IR_BUSRST   = 8'h80;
    localparam regbyte_t SEQ_DONE    = 8'h04;

    typedef enum logic [6:0] {
        OP_NOP     = 7'h00,
        OP_FLUSH   = 7'h01,
        OP_CHIPRST = 7'h02,
        OP_BUSRST  = 7'h03
    } opcode_e;

    typedef struct packed {
        logic wr_go;
        logic rd_go;
        logic intr_rd;
        logic cnt_wr;
        logic hi_wr;
        logic dma_load;
        logic chip_rst;
        logic bus_rst;
        logic mirror;
    } dec_t;

    function automatic logic is_count(input logic [AW-1:0] a);
        return (int'(a) >= A_CNT_LO) && (int'(a) <= A_CNT_HI);
    endfunction

    function automatic logic is_mirrored(input logic [AW-1:0] a);
        return (int'(a) == A_CMD) ||
               ((int'(a) >= A_CFG1) && (int'(a) <= A_SPARE1));
    endfunction
endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  regbyte_t      wr_data,
    output dec_t          dec
);
    logic cmd_wr;

    always_comb begin
        cmd_wr       = wr_en && (int'(addr) == A_CMD);
        dec          = '0;
        dec.wr_go    = wr_en;
        dec.rd_go    = rd_en && !wr_en;
        dec.intr_rd  = dec.rd_go && (int'(addr) == A_INTR);
        dec.cnt_wr   = wr_en && is_count(addr);
        dec.hi_wr    = wr_en && (int'(addr) == A_CNT_HI);
        dec.mirror   = wr_en && is_mirrored(addr);
        dec.dma_load = cmd_wr && wr_data[CMD_DMA];
        dec.chip_rst = cmd_wr && (wr_data[6:0] == OP_CHIPRST);
        dec.bus_rst  = cmd_wr && (wr_data[6:0] == OP_BUSRST);
    end
endmodule

// File: rtl/csr_irq.sv
module csr_irq (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic raise,
    input  logic lower,
    output logic irq
);
    // raise wins over a lower in the same cycle: the event follows the clear
    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            irq <= 1'b0;
        else if (raise && !irq)
            irq <= 1'b1;
        else if (lower && !raise && irq)
            irq <= 1'b0;
    end

    AST_IRQ_RAISE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (raise && !soft_rst) |=> irq); // R2
endmodule

// File: rtl/csr_rdmux.sv
module csr_rdmux
    import csr_pkg::*;
#(
    parameter regbyte_t CHIP_ID = 8'hA2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic          hi_wr,
    input  logic [AW-1:0] addr,
    input  regfile_t      rd_q,
    input  logic          irq,
    output regbyte_t      value
);
    logic hi_seen;

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            hi_seen <= 1'b0;
        else if (hi_wr)
            hi_seen <= 1'b1;
    end

    always_comb begin
        value = rd_q[addr];
        if (int'(addr) == A_CNT_HI && !hi_seen)
            value = CHIP_ID;
        else if (int'(addr) == A_STAT)
            value[ST_INT] = irq;
    end

    AST_HI_SEEN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (hi_seen && !soft_rst) |=> hi_seen); // R4
endmodule

// File: rtl/ctl_status_regs.sv
module ctl_status_regs
    import csr_pkg::*;
#(
    parameter regbyte_t CHIP_ID      = 8'hA2,
    parameter regbyte_t CFG1_DEFAULT = 8'h07
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          ev_valid,
    input  logic [DW-1:0] ev_reason,
    input  logic          ev_count_done,
    output logic          irq
);
    localparam int NCNT = A_CNT_HI - A_CNT_LO + 1;

    dec_t     dec;
    regfile_t rd_q;
    regbyte_t cnt_wq [NCNT];
    regbyte_t rd_value;
    regbyte_t intr_base;
    regbyte_t intr_next;
    logic     irq_raise;

    csr_decode u_dec (
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_data (wr_data),
        .dec     (dec)
    );

    always_comb begin
        if (dec.bus_rst)
            intr_base = IR_BUSRST;
        else if (dec.intr_rd)
            intr_base = '0;
        else
            intr_base = rd_q[A_INTR];
        intr_next = intr_base | (ev_valid ? ev_reason : '0);
        irq_raise = ev_valid || (dec.bus_rst && !rd_q[A_CFG1][CFG1_NOREPORT]);
    end

    csr_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (dec.chip_rst),
        .raise    (irq_raise),
        .lower    (dec.intr_rd),
        .irq      (irq)
    );

    csr_rdmux #(.CHIP_ID(CHIP_ID)) u_rdmux (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (dec.chip_rst),
        .hi_wr    (dec.hi_wr),
        .addr     (addr),
        .rd_q     (rd_q),
        .irq      (irq),
        .value    (rd_value)
    );

    // write-side count bytes
    generate
        for (genvar g = 0; g < NCNT; g++) begin : g_cnt
            always_ff @(posedge clk) begin
                if (rst || dec.chip_rst)
                    cnt_wq[g] <= '0;
                else if (wr_en && int'(addr) == A_CNT_LO + g)
                    cnt_wq[g] <= wr_data;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || dec.chip_rst) begin
            rd_q         <= '0;
            rd_q[A_CFG1] <= CFG1_DEFAULT;
            rd_data      <= '0;
        end else begin
            if (dec.mirror)
                rd_q[addr] <= wr_data;
            if (dec.dma_load)
                for (int i = 0; i < NCNT; i++)
                    rd_q[A_CNT_LO + i] <= cnt_wq[i];
            if (dec.cnt_wr || dec.intr_rd)
                rd_q[A_STAT][ST_DONE] <= 1'b0;
            if (ev_count_done)
                rd_q[A_STAT][ST_DONE] <= 1'b1;
            rd_q[A_INTR] <= intr_next;
            if (dec.intr_rd)
                rd_q[A_SEQ] <= SEQ_DONE;
            if (dec.rd_go)
                rd_data <= rd_value;
        end
    end

    AST_EVENT_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !dec.chip_rst) |=> irq); // R2
    AST_INTR_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && int'(addr) == A_INTR && !ev_valid) |=> !irq); // R3
    AST_INTR_READ_SETS_SEQ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && int'(addr) == A_INTR) |=> rd_q[A_SEQ] == SEQ_DONE); // R3
    AST_COUNT_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_count(addr) && !ev_count_done) |=> !rd_q[A_STAT][ST_DONE]); // R5
    AST_MUTED_BUSRST: assert property (@(posedge clk) disable iff (rst)
        (dec.bus_rst && rd_q[A_CFG1][CFG1_NOREPORT] && !ev_valid && !irq) |=> !irq); // R7
    AST_CHIPRST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        dec.chip_rst |=> (rd_q[A_CFG1] == CFG1_DEFAULT && !irq)); // R8
    AST_COLLIDE_HOLDS_RDATA: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && !dec.chip_rst) |=> $stable(rd_data)); // R10
endmodule

// File: tb/test_ctl_status_regs.sv
`timescale 1ns/1ps
module test_ctl_status_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       ev_valid = 1'b0;
    logic [7:0] ev_reason = '0;
    logic       ev_count_done = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [7:0] ID = 8'hA2;

    always #2.5 clk = ~clk;

    ctl_status_regs i_ctl_status_regs (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .ev_valid(ev_valid),
        .ev_reason(ev_reason), .ev_count_done(ev_count_done), .irq(irq)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        addr = 4'(a); wr_data = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        addr = 4'(a); rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic pulse_ev(input logic [7:0] r);
        ev_valid = 1'b1; ev_reason = r;
        cyc();
        ev_valid = 1'b0; ev_reason = '0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rd(8, v);  chk("R1 cfg1", v, 8'h07);
        rd(4, v);  chk("R1 status", v, 8'h00);
        rd(5, v);  chk("R1 intr", v, 8'h00);
        rd(2, v);  chk("R1 hi identity", v, ID);
        rd(0, v);  chk("R1 count lo", v, 8'h00);
        rd(9, v);  chk("R1 cfg2", v, 8'h00);
    endtask

    task automatic t_event();
        logic [7:0] v;
        pulse_ev(8'h18);
        chk("R2 irq after event", {7'd0, irq}, 8'h01);
        rd(4, v);  chk("R2 status int bit", v, 8'h80);
        pulse_ev(8'h01);
        rd(5, v);  chk("R3 intr returns old", v, 8'h19);
        chk("R3 irq dropped", {7'd0, irq}, 8'h00);
        rd(5, v);  chk("R3 intr cleared", v, 8'h00);
        rd(6, v);  chk("R3 seq step", v, 8'h04);
        rd(4, v);  chk("R3 status after", v, 8'h00);
    endtask

    task automatic t_count_done();
        logic [7:0] v;
        ev_count_done = 1'b1; cyc(); ev_count_done = 1'b0;
        rd(4, v);  chk("R5 done set", v, 8'h10);
        wr(1, 8'h33);
        rd(4, v);  chk("R5 count write clears done", v, 8'h00);
        ev_count_done = 1'b1; cyc(); ev_count_done = 1'b0;
        rd(5, v);
        rd(4, v);  chk("R3 intr read clears done", v, 8'h00);
    endtask

    task automatic t_identity();
        logic [7:0] v;
        rd(2, v);  chk("R4 identity before write", v, ID);
        wr(2, 8'h5C);
        rd(2, v);  chk("R4 stored after write", v, 8'h00);
        wr(0, 8'h11);
        wr(1, 8'h22);
        wr(3, 8'h00);
        rd(0, v);  chk("R6 no load without flag", v, 8'h00);
        wr(3, 8'h80);
        rd(0, v);  chk("R6 lo loaded", v, 8'h11);
        rd(1, v);  chk("R6 mid loaded", v, 8'h22);
        rd(2, v);  chk("R6 hi loaded", v, 8'h5C);
        rd(3, v);  chk("R6 command readback", v, 8'h80);
    endtask

    task automatic t_busreset();
        logic [7:0] v;
        wr(8, 8'h07);
        wr(3, 8'h03);
        chk("R7 irq reported", {7'd0, irq}, 8'h01);
        rd(5, v);  chk("R7 reason", v, 8'h80);
        wr(8, 8'h47);
        wr(3, 8'h03);
        chk("R7 irq muted", {7'd0, irq}, 8'h00);
        rd(5, v);  chk("R7 reason when muted", v, 8'h80);
        wr(8, 8'h07);
    endtask

    task automatic t_mirror();
        logic [7:0] v;
        wr(9, 8'h3C);  rd(9, v);  chk("R9 cfg2", v, 8'h3C);
        wr(12, 8'hA5); rd(12, v); chk("R9 spare", v, 8'hA5);
        wr(4, 8'hFF);  rd(4, v);  chk("R9 status untouched", v, 8'h00);
        wr(6, 8'hFF);  rd(6, v);  chk("R9 seq untouched", v, 8'h04);
        wr(13, 8'h55); rd(13, v); chk("R9 write-only", v, 8'h00);
        chk("R9 irq untouched", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        rd(9, v);
        pulse_ev(8'h01);
        addr = 4'd5; wr_data = 8'hFF; wr_en = 1'b1; rd_en = 1'b1;
        cyc();
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 rd_data held", rd_data, 8'h3C);
        chk("R10 irq kept", {7'd0, irq}, 8'h01);
        addr = 4'd9; wr_data = 8'h99; wr_en = 1'b1; rd_en = 1'b1;
        cyc();
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 rd_data held on cfg2", rd_data, 8'h3C);
        rd(9, v);  chk("R10 write applied", v, 8'h99);
        rd(5, v);  chk("R10 intr not cleared", v, 8'h01);
    endtask

    task automatic t_coincide();
        logic [7:0] v;
        pulse_ev(8'h02);
        addr = 4'd5; rd_en = 1'b1; ev_valid = 1'b1; ev_reason = 8'h04;
        cyc();
        rd_en = 1'b0; ev_valid = 1'b0; ev_reason = '0;
        chk("R11 old value read", rd_data, 8'h02);
        chk("R11 irq stays", {7'd0, irq}, 8'h01);
        rd(5, v);  chk("R11 new reason kept", v, 8'h04);
    endtask

    task automatic t_softreset();
        logic [7:0] v;
        wr(9, 8'h77);
        wr(2, 8'h01);
        pulse_ev(8'h08);
        wr(3, 8'h02);
        chk("R8 irq dropped", {7'd0, irq}, 8'h00);
        rd(8, v);  chk("R8 cfg1", v, 8'h07);
        rd(9, v);  chk("R8 cfg2", v, 8'h00);
        rd(2, v);  chk("R8 identity rearmed", v, ID);
        rd(5, v);  chk("R8 intr", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_event();
        t_count_done();
        t_identity();
        t_busreset();
        t_mirror();
        t_collide();
        t_coincide();
        t_softreset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule